// File: doc/BRIEF.md
# Ring and Bounds Write-Access Checker

This block decides whether an operand write to a segment may go ahead. For one store it takes the segment descriptor's three ring brackets, its write-permit bit and its bound, the word offset being written, and the segment and ring numbers of the target and of the running procedure. It does not stop at the first problem. It evaluates every access rule in the same pass and merges all the violations it finds into one 16-bit mask.

A check begins with a one-cycle `start` pulse. One clock edge later the block registers the result:
- the violation mask;
- the effective ring the store runs at;
- a copy of the descriptor's lowest bracket.

If any mask bit is set, it also raises a single-cycle fault strobe. The mask is that fault's subtype. A zero mask means the store may proceed. Address translation is out of scope.

Top module: `ring_bounds_store_chk`

## Requirements
- R1: When the brackets do not satisfy `brk_lo <= brk_mid <= brk_hi`, mask bit 0 is set.
- R2: When `tgt_seg` equals `cur_seg`, `cur_ring` replaces `tgt_ring` for the ring check, and `eff_ring` shows the replaced value.
- R3: When the ring used for the check is greater than `brk_lo`, mask bit 5 is set. An equal ring does not set it.
- R4: When `wr_permit` is 0, mask bit 6 is set and `eff_ring` becomes `cur_ring`.
- R5: When `offset[17:4]` is greater than `bound`, mask bit 15 is set. An equal value does not set it.
- R6: Mask bits other than 0, 5, 6 and 15 are always 0.
- R7: `fault` goes high for exactly one cycle, in the cycle after a `start`, if and only if the new mask is nonzero.
- R8: `viol_mask`, `eff_ring` and `held_lo` change only in the cycle after a `start`. Otherwise they keep their values.
- R9: Each `start` copies `brk_lo` into `held_lo`.
- R10: While reset is asserted and after its release, all outputs are 0 until the first `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a check with the inputs sampled at this edge |
| brk_lo | input | 3 | Lowest ring bracket of the descriptor |
| brk_mid | input | 3 | Middle ring bracket |
| brk_hi | input | 3 | Highest ring bracket |
| wr_permit | input | 1 | Descriptor write permission |
| bound | input | 14 | Segment bound in 16-word blocks |
| offset | input | 18 | Word offset of the store |
| tgt_seg | input | 15 | Target segment number |
| cur_seg | input | 15 | Segment of the running procedure |
| tgt_ring | input | 3 | Target ring number |
| cur_ring | input | 3 | Ring of the running procedure |
| viol_mask | output | 16 | Accumulated violations of the last check |
| fault | output | 1 | One-cycle access-violation strobe |
| eff_ring | output | 3 | Effective ring after substitution |
| held_lo | output | 3 | Lowest bracket captured at the last check |

## Verification
Every result is due one edge after the `start` that sampled its inputs:
- `viol_mask`, `eff_ring` and `held_lo` take their new values at that edge.
- `fault` is high for only that one cycle.

The bench's reference model updates its expectations on the same edge. The outputs are compared on the falling edge that follows, so each value is sampled half a period after it settles.

In cycles without a `start`, the same comparison confirms that the registered outputs have held and that `fault` is low.

// File: rtl/rbw_pkg.sv
package rbw_pkg;
    localparam int RING_W  = 3;
    localparam int SEG_W   = 15;
    localparam int OFF_W   = 18;
    localparam int BND_W   = 14;
    localparam int GRAN_SH = 4;
    localparam int MASK_W  = 16;

    // Mask bit positions decoded by the fault handler
    localparam int V_ORDER = 0;
    localparam int V_RING  = 5;
    localparam int V_WRITE = 6;
    localparam int V_BOUND = 15;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic              fault;
        logic [RING_W-1:0] ring;
        logic [RING_W-1:0] lo;
    } chk_state_t;
endpackage

// File: rtl/bracket_order.sv
module bracket_order #(
    parameter int RING_W = 3
) (
    input  logic [RING_W-1:0] lo,
    input  logic [RING_W-1:0] mid,
    input  logic [RING_W-1:0] hi,
    output logic              bad
);
    always_comb begin
        bad = !((lo <= mid) && (mid <= hi));
    end
endmodule

// File: rtl/ring_select.sv
module ring_select #(
    parameter int RING_W = 3,
    parameter int SEG_W  = 15
) (
    input  logic [SEG_W-1:0]  tgt_seg,
    input  logic [SEG_W-1:0]  cur_seg,
    input  logic [RING_W-1:0] tgt_ring,
    input  logic [RING_W-1:0] cur_ring,
    input  logic [RING_W-1:0] lo,
    input  logic              wr_permit,
    output logic              ring_bad,
    output logic [RING_W-1:0] eff
);
    logic [RING_W-1:0] chk_ring;

    always_comb begin
        chk_ring = (tgt_seg == cur_seg) ? cur_ring : tgt_ring;
        ring_bad = chk_ring > lo;
        eff      = wr_permit ? chk_ring : cur_ring;
    end
endmodule

// File: rtl/bound_check.sv
module bound_check #(
    parameter int OFF_W   = 18,
    parameter int BND_W   = 14,
    parameter int GRAN_SH = 4
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [BND_W-1:0] bound,
    output logic             over
);
    localparam int BLK_W = OFF_W - GRAN_SH;
    localparam int CMP_W = (BLK_W > BND_W) ? BLK_W : BND_W;

    logic [CMP_W-1:0] blk_x;
    logic [CMP_W-1:0] bnd_x;

    generate
        if (CMP_W == BLK_W) begin : g_blk_full
            assign blk_x = offset[OFF_W-1:GRAN_SH];
        end else begin : g_blk_ext
            assign blk_x = {{(CMP_W-BLK_W){1'b0}}, offset[OFF_W-1:GRAN_SH]};
        end
        if (CMP_W == BND_W) begin : g_bnd_full
            assign bnd_x = bound;
        end else begin : g_bnd_ext
            assign bnd_x = {{(CMP_W-BND_W){1'b0}}, bound};
        end
    endgenerate

    always_comb begin
        over = blk_x > bnd_x;
    end
endmodule

// File: rtl/ring_bounds_store_chk.sv
module ring_bounds_store_chk
    import rbw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RING_W-1:0] brk_lo,
    input  logic [RING_W-1:0] brk_mid,
    input  logic [RING_W-1:0] brk_hi,
    input  logic              wr_permit,
    input  logic [BND_W-1:0]  bound,
    input  logic [OFF_W-1:0]  offset,
    input  logic [SEG_W-1:0]  tgt_seg,
    input  logic [SEG_W-1:0]  cur_seg,
    input  logic [RING_W-1:0] tgt_ring,
    input  logic [RING_W-1:0] cur_ring,
    output logic [MASK_W-1:0] viol_mask,
    output logic              fault,
    output logic [RING_W-1:0] eff_ring,
    output logic [RING_W-1:0] held_lo
);
    localparam logic [MASK_W-1:0] USED_BITS =
        (MASK_W'(1) << V_ORDER) | (MASK_W'(1) << V_RING) |
        (MASK_W'(1) << V_WRITE) | (MASK_W'(1) << V_BOUND);

    logic              order_bad;
    logic              ring_bad;
    logic              bound_over;
    logic [RING_W-1:0] eff_d;
    chk_state_t        st_d, st_q;

    bracket_order #(.RING_W(RING_W)) u_order (
        .lo  (brk_lo),
        .mid (brk_mid),
        .hi  (brk_hi),
        .bad (order_bad)
    );

    ring_select #(.RING_W(RING_W), .SEG_W(SEG_W)) u_ring (
        .tgt_seg   (tgt_seg),
        .cur_seg   (cur_seg),
        .tgt_ring  (tgt_ring),
        .cur_ring  (cur_ring),
        .lo        (brk_lo),
        .wr_permit (wr_permit),
        .ring_bad  (ring_bad),
        .eff       (eff_d)
    );

    bound_check #(.OFF_W(OFF_W), .BND_W(BND_W), .GRAN_SH(GRAN_SH)) u_bound (
        .offset (offset),
        .bound  (bound),
        .over   (bound_over)
    );

    always_comb begin
        st_d       = st_q;
        st_d.fault = 1'b0;
        if (start) begin
            st_d.mask          = '0;
            st_d.mask[V_ORDER] = order_bad;
            st_d.mask[V_RING]  = ring_bad;
            st_d.mask[V_WRITE] = !wr_permit;
            st_d.mask[V_BOUND] = bound_over;
            st_d.fault         = |st_d.mask;
            st_d.ring          = eff_d;
            st_d.lo            = brk_lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign viol_mask = st_q.mask;
    assign fault     = st_q.fault;
    assign eff_ring  = st_q.ring;
    assign held_lo   = st_q.lo;

    assert_spare_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_mask & ~USED_BITS) == '0);
    assert_fault_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(start));
    assert_fault_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (viol_mask != '0));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(viol_mask) && $stable(eff_ring) && $stable(held_lo) && !fault));
    assert_capture_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (held_lo == $past(brk_lo)));
    assert_nowrite_ring_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !wr_permit) |=> (eff_ring == $past(cur_ring) && viol_mask[V_WRITE]));
endmodule

// File: tb/sim_ring_bounds_store_chk.sv
module sim_ring_bounds_store_chk;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  brk_lo = '0, brk_mid = '0, brk_hi = '0;
    logic        wr_permit = 1'b1;
    logic [13:0] bound = '0;
    logic [17:0] offset = '0;
    logic [14:0] tgt_seg = '0, cur_seg = '0;
    logic [2:0]  tgt_ring = '0, cur_ring = '0;
    logic [15:0] viol_mask;
    logic        fault;
    logic [2:0]  eff_ring, held_lo;

    int checks = 0;
    int fails  = 0;
    bit running = 1'b0;
    bit finished = 1'b0;

    int exp_mask = 0, exp_fault = 0, exp_ring = 0, exp_lo = 0;
    bit upd = 1'b0, same_seg = 1'b0;

    always #10 clk = ~clk;

    ring_bounds_store_chk u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .brk_lo(brk_lo), .brk_mid(brk_mid), .brk_hi(brk_hi),
        .wr_permit(wr_permit), .bound(bound), .offset(offset),
        .tgt_seg(tgt_seg), .cur_seg(cur_seg),
        .tgt_ring(tgt_ring), .cur_ring(cur_ring),
        .viol_mask(viol_mask), .fault(fault),
        .eff_ring(eff_ring), .held_lo(held_lo)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model: behavioural, updated on the sampling edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_mask = 0; exp_fault = 0; exp_ring = 0; exp_lo = 0; upd = 0;
        end else begin
            upd = start;
            exp_fault = 0;
            if (start) begin
                int ring;
                int m;
                same_seg = (tgt_seg == cur_seg);
                ring = same_seg ? int'(cur_ring) : int'(tgt_ring);
                m = 0;
                if (!(brk_lo <= brk_mid && brk_mid <= brk_hi)) m += 1;
                if (ring > int'(brk_lo)) m += 32;
                if (!wr_permit) begin m += 64; ring = int'(cur_ring); end
                if (int'(offset / 16) > int'(bound)) m += 32768;
                exp_mask = m;
                exp_fault = (m != 0);
                exp_ring = ring;
                exp_lo = int'(brk_lo);
            end
        end
    end

    always @(negedge clk) begin
        if (running) begin
            chk(viol_mask[0] == exp_mask[0], upd ? "R1 order bit" : "R8 hold bit0", viol_mask[0], exp_mask[0]);
            chk(viol_mask[5] == exp_mask[5], upd ? "R3 ring bit" : "R8 hold bit5", viol_mask[5], exp_mask[5]);
            chk(viol_mask[6] == exp_mask[6], upd ? "R4 write bit" : "R8 hold bit6", viol_mask[6], exp_mask[6]);
            chk(viol_mask[15] == exp_mask[15], upd ? "R5 bound bit" : "R8 hold bit15", viol_mask[15], exp_mask[15]);
            chk((viol_mask & 16'h7F9E) == 0, "R6 spare bits", viol_mask, 0);
            chk(int'(fault) == exp_fault, "R7 fault strobe", fault, exp_fault);
            chk(int'(eff_ring) == exp_ring, (upd && same_seg) ? "R2 substituted ring" : "R4/R8 eff ring", eff_ring, exp_ring);
            chk(int'(held_lo) == exp_lo, upd ? "R9 held bracket" : "R8 hold bracket", held_lo, exp_lo);
        end
    end

    task automatic one(input int lo, input int mid, input int hi, input bit w,
                       input int bnd, input int off, input int ts, input int cs,
                       input int tr, input int cr);
        @(negedge clk);
        brk_lo = 3'(lo); brk_mid = 3'(mid); brk_hi = 3'(hi); wr_permit = w;
        bound = 14'(bnd); offset = 18'(off); tgt_seg = 15'(ts); cur_seg = 15'(cs);
        tgt_ring = 3'(tr); cur_ring = 3'(cr); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // scramble inputs: must not disturb outputs (R8)
        brk_lo = ~brk_lo; wr_permit = ~wr_permit; offset = ~offset;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(viol_mask == 0 && fault == 0 && eff_ring == 0 && held_lo == 0,
            "R10 reset outputs", {viol_mask, fault, eff_ring, held_lo}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(viol_mask == 0 && fault == 0, "R10 after release", viol_mask, 0);
        running = 1'b1;
        one(4, 4, 4, 1, 10, 10 * 16 + 15, 7, 9, 4, 1);   // all legal, bound equal
        one(5, 3, 6, 1, 10, 0, 7, 9, 0, 0);              // R1
        one(2, 3, 2, 1, 10, 0, 7, 9, 0, 0);              // R1 mid > hi
        one(4, 4, 4, 1, 10, 11 * 16, 7, 9, 0, 0);        // R5 bound exceeded
        one(4, 4, 4, 1, 10, 0, 7, 9, 5, 0);              // R3 ring above
        one(4, 4, 4, 1, 10, 0, 7, 7, 7, 2);              // R2 substitution hides ring
        one(4, 4, 4, 1, 10, 0, 7, 7, 0, 6);              // R2 substitution raises ring
        one(4, 5, 6, 0, 10, 0, 7, 9, 1, 3);              // R4 write off
        one(1, 0, 0, 0, 0, 18'h3FFFF, 3, 9, 7, 2);       // all four bits
        one(0, 0, 0, 1, 16383, 18'h3FFFF, 1, 2, 0, 0);   // max offset, max bound
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            brk_lo = 3'($urandom); brk_mid = 3'($urandom); brk_hi = 3'($urandom);
            wr_permit = 1'($urandom); bound = 14'($urandom); offset = 18'($urandom);
            tgt_seg = 15'($urandom % 4); cur_seg = 15'($urandom % 4);
            tgt_ring = 3'($urandom); cur_ring = 3'($urandom);
            start = 1'($urandom);
        end
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        running = 1'b0;
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule